// File: doc/BRIEF.md
# Four-Channel DShot Frame Transmitter

This block drives four motor-control serial lines from one shared timing base. On a start strobe it captures four throttle words, scales each one into an 11-bit command, and builds a 16-bit frame for each channel. Each frame carries a zero telemetry-request bit and a nibble-XOR checksum. It then sends the four frames together, one fixed-length pulse-width slot per bit. All four lines rise and fall on the same slot grid and end together after two trailing idle slots.

A tick enable is derived on chip from the system clock by a prescaler. The divider is `DIV_BASE` cycles for the slowest rate and halves with each rate step. A frame therefore takes 342 ticks whatever rate is selected. While a frame is in flight the block reports busy and ignores further start strobes. Software-visible state, DMA and telemetry return are not part of the block.

Top module: `dshot_quad_tx`

## Requirements
- R1: After reset `busy_o` is 0 and every bit of `dshot_o` is 0.
- R2: Each throttle word is first clamped to [`lim_lo_i`, `lim_hi_i`] and then scaled to floor(2000*(clamped-lo)/(hi-lo)). A nonzero result has 47 added, giving 48 to 2047. A result of 0 is sent as 0 (motor off). When hi <= lo the command is 0.
- R3: The frame is {cmd[10:0], 1'b0, csum[3:0]}. Here csum is the XOR of bits [11:8], [7:4] and [3:0] of the 12-bit word {cmd, 1'b0}. For example, with lo=1000, hi=2000 and throttle 1500 the frame is 16'h82E4.
- R4: Frame bits leave most significant bit first. Slot 0 carries bit 15.
- R5: A slot lasts 19 ticks. A one is high for the first 14 ticks and a zero for the first 7 ticks. The line is low for the rest of the slot.
- R6: After the 16 data slots come 2 slots with the line held low, for 18 slots per frame.
- R7: `rate_sel_i` selects 0=150, 1=300, 2=600 and 3=1200 kbit/s. One tick lasts DIV_BASE>>rate_sel clock cycles. The rate is captured with the start strobe.
- R8: All four channels start their frames in the same cycle and share the slot timeline. In the first 7 ticks of every data slot all four lines are high.
- R9: A start strobe while idle raises `busy_o` on the next cycle. `busy_o` then stays high for exactly 342 ticks. A start strobe while busy is ignored.
- R10: Throttles, limits and rate are captured at the accepted start. Changes to them during a frame do not alter the frame.
- R11: All lines are low whenever `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to send a frame set |
| rate_sel_i | input | 2 | Bit-rate select (0..3 = 150..1200 kbit/s) |
| thr_i | input | NCH*TW | Packed throttle words, channel 0 in the low bits |
| lim_lo_i | input | TW | Lower throttle bound |
| lim_hi_i | input | TW | Upper throttle bound |
| busy_o | output | 1 | High while a frame set is being sent |
| dshot_o | output | NCH | Serial pulse-width outputs, one per channel |

## Verification
The hardest case to reach from the ports is a start strobe that arrives deep inside a frame, together with new throttles, new limits and a new rate. A faulty design might reload the frame registers or the prescaler partway through a slot. The directed frame task can apply such a disturbance at a chosen cycle. It then still compares every cycle of all four lines against a waveform computed from the values captured at launch, and it checks that busy keeps its exact length. Clamping above and below the limits, a zero command, the degenerate case of equal limits, and all four rates are each driven through the same cycle-exact comparison.

// File: rtl/dshot_pkg.sv
package dshot_pkg;
  localparam int SLOT_TICKS  = 19;
  localparam int HI_ONE      = 14;
  localparam int HI_ZERO     = 7;
  localparam int DATA_SLOTS  = 16;
  localparam int TAIL_SLOTS  = 2;
  localparam int TOTAL_SLOTS = DATA_SLOTS + TAIL_SLOTS;
  localparam int SLOT_W      = $clog2(TOTAL_SLOTS);
  localparam int TICK_W      = $clog2(SLOT_TICKS);
  localparam int CMD_W       = 11;
  localparam int FULL_SCALE  = 2000;
  localparam int CMD_OFFSET  = 47;

  // clamp, scale and offset a throttle word into an 11-bit command
  function automatic logic [CMD_W-1:0] scale_thr(input logic [31:0] v,
                                                 input logic [31:0] lo,
                                                 input logic [31:0] hi);
    logic [31:0] c, q;
    if (hi <= lo) return '0;
    c = (v < lo) ? lo : ((v > hi) ? hi : v);
    q = (32'(FULL_SCALE) * (c - lo)) / (hi - lo);
    if (q == 0) return '0;
    return CMD_W'(q + 32'(CMD_OFFSET));
  endfunction

  function automatic logic [3:0] nib_xor(input logic [11:0] w);
    return w[11:8] ^ w[7:4] ^ w[3:0];
  endfunction

  function automatic logic [15:0] build_frame(input logic [CMD_W-1:0] cmd);
    logic [11:0] w;
    w = {cmd, 1'b0};
    return {w, nib_xor(w)};
  endfunction
endpackage

// File: rtl/dshot_tick_gen.sv
module dshot_tick_gen #(
  parameter int DIV_BASE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int CW = (DIV_BASE > 1) ? $clog2(DIV_BASE) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim  = CW'((DIV_BASE >> sel) - 1);
  assign tick = (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || tick) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dshot_slot_seq.sv
module dshot_slot_seq
  import dshot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              tick,
  output logic              busy,
  output logic [SLOT_W-1:0] slot,
  output logic [TICK_W-1:0] tcnt,
  output logic              frame_end
);
  logic slot_end;

  assign slot_end  = busy && tick && (tcnt == TICK_W'(SLOT_TICKS - 1));
  assign frame_end = slot_end && (slot == SLOT_W'(TOTAL_SLOTS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      slot <= '0;
      tcnt <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      slot <= '0;
      tcnt <= '0;
    end else if (busy && tick) begin
      if (slot_end) begin
        tcnt <= '0;
        if (frame_end) begin
          busy <= 1'b0;
          slot <= '0;
        end else begin
          slot <= slot + 1'b1;
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dshot_bit_enc.sv
module dshot_bit_enc
  import dshot_pkg::*;
(
  input  logic              busy,
  input  logic [15:0]       frame,
  input  logic [SLOT_W-1:0] slot,
  input  logic [TICK_W-1:0] tcnt,
  output logic              line
);
  logic [3:0]        idx;
  logic [TICK_W-1:0] hi_len;

  assign idx    = 4'(DATA_SLOTS - 1) - slot[3:0];
  assign hi_len = frame[idx] ? TICK_W'(HI_ONE) : TICK_W'(HI_ZERO);
  assign line   = busy && (slot < SLOT_W'(DATA_SLOTS)) && (tcnt < hi_len);
endmodule

// File: rtl/dshot_quad_tx.sv
module dshot_quad_tx
  import dshot_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int TW       = 16,
  parameter int DIV_BASE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        rate_sel_i,
  input  logic [NCH*TW-1:0] thr_i,
  input  logic [TW-1:0]     lim_lo_i,
  input  logic [TW-1:0]     lim_hi_i,
  output logic              busy_o,
  output logic [NCH-1:0]    dshot_o
);
  localparam int FW = DATA_SLOTS;

  logic              busy;
  logic              launch;
  logic              tick;
  logic              frame_end;
  logic [1:0]        rate_q;
  logic [SLOT_W-1:0] slot_q;
  logic [TICK_W-1:0] tick_q;
  logic [NCH*FW-1:0] frm_all;

  assign launch = start_i && !busy;
  assign busy_o = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rate_q <= '0;
    else if (launch) rate_q <= rate_sel_i;
  end

  dshot_tick_gen #(.DIV_BASE(DIV_BASE)) tick_i (
    .clk(clk), .rst_n(rst_n), .clr(launch), .sel(rate_q), .tick(tick)
  );

  dshot_slot_seq seq_i (
    .clk(clk), .rst_n(rst_n), .launch(launch), .tick(tick),
    .busy(busy), .slot(slot_q), .tcnt(tick_q), .frame_end(frame_end)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CMD_W-1:0] cmd_w;
    logic [FW-1:0]    frame_w;
    logic [FW-1:0]    frm_q;

    assign cmd_w   = scale_thr(32'(thr_i[ch*TW +: TW]), 32'(lim_lo_i), 32'(lim_hi_i));
    assign frame_w = build_frame(cmd_w);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      frm_q <= '0;
      else if (launch) frm_q <= frame_w;
    end

    assign frm_all[ch*FW +: FW] = frm_q;

    dshot_bit_enc enc_i (
      .busy(busy), .frame(frm_q), .slot(slot_q), .tcnt(tick_q), .line(dshot_o[ch])
    );
  end
endmodule

// File: rtl/dshot_quad_tx_chk.sv
module dshot_quad_tx_chk
  import dshot_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              tick,
  input logic [SLOT_W-1:0] slot,
  input logic [TICK_W-1:0] tcnt,
  input logic [NCH*16-1:0] frm_all,
  input logic [NCH-1:0]    dshot
);
  // R11: lines quiet while idle
  a_r11_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> dshot == '0);

  // R6: trailing slots carry no pulse
  a_r6_tail_low: assert property (@(posedge clk) disable iff (!rst_n)
    busy && slot >= SLOT_W'(DATA_SLOTS) |-> dshot == '0);

  // R5: no line high past the longest pulse
  a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tcnt >= TICK_W'(HI_ONE) |-> dshot == '0);

  // R5: counters stay inside the slot grid
  a_r5_grid_range: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt <= TICK_W'(SLOT_TICKS - 1) && slot <= SLOT_W'(TOTAL_SLOTS - 1));

  // R8: every channel high at the start of each data slot
  a_r8_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
    busy && slot < SLOT_W'(DATA_SLOTS) && tcnt < TICK_W'(HI_ZERO) |-> dshot == '1);

  // R9: idle start launches a fresh frame
  a_r9_launch: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy && slot == '0 && tcnt == '0);

  // R9: start while busy leaves captured frames alone
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(frm_all));

  // R9: busy ends only after the last tick of the last slot
  a_r9_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(slot) == SLOT_W'(TOTAL_SLOTS - 1)
                 && $past(tcnt) == TICK_W'(SLOT_TICKS - 1) && $past(tick));
endmodule

bind dshot_quad_tx dshot_quad_tx_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start_i), .busy(busy), .tick(tick),
  .slot(slot_q), .tcnt(tick_q), .frm_all(frm_all), .dshot(dshot_o)
);

// File: tb/dshot_quad_tx_tb_top.sv
module dshot_quad_tx_tb_top;
  localparam int NCH = 4;
  localparam int TW  = 16;
  localparam int DB  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [1:0]        rate_sel_i = '0;
  logic [NCH*TW-1:0] thr_i = '0;
  logic [TW-1:0]     lim_lo_i = '0;
  logic [TW-1:0]     lim_hi_i = '0;
  logic              busy_o;
  logic [NCH-1:0]    dshot_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dshot_quad_tx #(.NCH(NCH), .TW(TW), .DIV_BASE(DB)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rate_sel_i(rate_sel_i),
    .thr_i(thr_i), .lim_lo_i(lim_lo_i), .lim_hi_i(lim_hi_i),
    .busy_o(busy_o), .dshot_o(dshot_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
               req, what, act, act, exp, exp);
    end
  endtask

  function automatic int ref_cmd(input int v, input int lo, input int hi);
    int c, q;
    if (hi <= lo) return 0;
    c = v;
    if (c < lo) c = lo;
    if (c > hi) c = hi;
    q = (2000 * (c - lo)) / (hi - lo);
    return (q == 0) ? 0 : q + 47;
  endfunction

  function automatic logic [15:0] ref_frame(input int cmd);
    logic [11:0] w;
    logic [3:0]  cs;
    w  = 12'(cmd * 2);
    cs = 4'h0;
    for (int n = 0; n < 3; n++) cs = cs ^ w[n*4 +: 4];
    return {w, cs};
  endfunction

  // send one frame set and compare every cycle; disturb >= 0 injects a
  // start strobe with new inputs at that cycle of the frame
  task automatic run_frame(input int t0, input int t1, input int t2, input int t3,
                           input int lo, input int hi, input int sel,
                           input int disturb, input string tag);
    int          thr[NCH];
    logic [15:0] expf[NCH];
    int          d, n, mism[NCH], hc[NCH][16], busy_bad, slot_i, tk;
    logic [15:0] got;
    bit          e;
    thr[0] = t0; thr[1] = t1; thr[2] = t2; thr[3] = t3;
    d = DB >> sel;
    n = 18 * 19 * d;
    for (int c = 0; c < NCH; c++) begin
      expf[c] = ref_frame(ref_cmd(thr[c], lo, hi));
      mism[c] = 0;
      for (int s = 0; s < 16; s++) hc[c][s] = 0;
    end
    busy_bad = 0;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) thr_i[c*TW +: TW] = TW'(thr[c]);
    lim_lo_i = TW'(lo); lim_hi_i = TW'(hi); rate_sel_i = 2'(sel);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(dshot_o == '1, "R8", {tag, " all lines rise together"}, int'(dshot_o), 15);
    for (int k = 0; k < n; k++) begin
      slot_i = k / (19 * d);
      tk     = (k % (19 * d)) / d;
      if (!busy_o) busy_bad++;
      for (int c = 0; c < NCH; c++) begin
        e = (slot_i < 16) && (tk < (expf[c][15 - slot_i] ? 14 : 7));
        if (dshot_o[c] != e) mism[c]++;
        if (slot_i < 16 && dshot_o[c]) hc[c][slot_i]++;
      end
      if (k == disturb) begin
        start_i = 1'b1;
        thr_i = ~thr_i;
        lim_lo_i = 16'd0; lim_hi_i = 16'd100; rate_sel_i = ~rate_sel_i;
      end
      if (k == disturb + 1) start_i = 1'b0;
      @(negedge clk);
    end
    chk(busy_bad == 0, "R9", {tag, " busy held through frame"}, busy_bad, 0);
    chk(!busy_o, "R9", {tag, " busy drops after 342 ticks"}, int'(busy_o), 0);
    chk(dshot_o == '0, "R11", {tag, " lines low after frame"}, int'(dshot_o), 0);
    for (int c = 0; c < NCH; c++) begin
      got = '0;
      for (int s = 0; s < 16; s++) got[15 - s] = (hc[c][s] == 14 * d);
      chk(got == expf[c], "R3", $sformatf("%s ch%0d frame MSB-first (R4)", tag, c),
          int'(got), int'(expf[c]));
      chk(mism[c] == 0, "R5", $sformatf("%s ch%0d cycle-exact slots, tail low (R6 R7)", tag, c),
          mism[c], 0);
    end
  endtask

  task automatic t_reset();
    #1;
    chk(busy_o == 1'b0, "R1", "busy in reset", int'(busy_o), 0);
    chk(dshot_o == '0, "R1", "lines in reset", int'(dshot_o), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(dshot_o == '0 && !busy_o, "R11", "idle after reset", int'(dshot_o), 0);
  endtask

  task automatic t_known_frame();
    chk(ref_frame(ref_cmd(1500, 1000, 2000)) == 16'h82E4, "R3", "bench frame model",
        int'(ref_frame(ref_cmd(1500, 1000, 2000))), 16'h82E4);
    run_frame(1500, 1500, 1500, 1500, 1000, 2000, 0, -1, "mid_r0");
  endtask

  task automatic t_scaling();
    // R2: below min (off), above max (2047), just above min, arbitrary
    run_frame(900, 2500, 1001, 1234, 1000, 2000, 3, -1, "clamp_r3");
    // R2: equal limits force command 0
    run_frame(5, 700, 65535, 300, 300, 300, 2, -1, "eq_lim");
  endtask

  task automatic t_rates();
    // R7: every rate select
    run_frame(1100, 1900, 1555, 2000, 1000, 2000, 1, -1, "rate1");
    run_frame(0, 65535, 40000, 12345, 0, 65535, 2, -1, "rate2");
  endtask

  task automatic t_disturb();
    // R9 R10: start and new inputs mid-frame have no effect
    run_frame(1300, 1700, 1000, 1999, 1000, 2000, 0, 777, "disturb_r0");
    run_frame(1450, 1020, 1880, 1600, 1000, 2000, 3, 150, "disturb_r3");
  endtask

  initial begin
    t_reset();
    t_known_frame();
    t_scaling();
    t_rates();
    t_disturb();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule